// File: doc/BRIEF.md
# Flash Fetch Wait-State Controller

This block sits between a processor's instruction-fetch port and a flash array that has a fixed read latency. It adds a programmable number of wait states to each flash read. It also has a power-saving option that holds back speculative fetches of conditional-branch targets. The core drives a fetch address, a flag that marks a fetch as a speculative branch-target prefetch, and a resolution strobe that reports whether the pending branch was taken. The flash side is a one-cycle read strobe with an address. The array returns its word in the next cycle and keeps it until the next read.

A two-bit mode register selects the wait-state count (none, or `SLOW_WS`) and whether suppression is on. In a suppressing mode a flagged prefetch is accepted but never reaches flash. Its address is parked until the branch resolves. A taken outcome replays the parked address to flash. A not-taken outcome drops it. A free-running counter records every read that actually reaches the array, so the flash traffic of the different modes can be compared.

Top module: `flash_fetch_ws_ctrl`

## Requirements
- R1: After reset the mode reads 2'b00, the read counter is zero, `fetch_ready_o` is high, and neither `flash_rd_o` nor `fetch_rvalid_o` is asserted.
- R2: Mode encoding is 2'b00 no wait states, 2'b01 `SLOW_WS` wait states, 2'b10 no wait states with suppression, 2'b11 `SLOW_WS` wait states with suppression. A write strobe loads `mode_wdata_i` when no flash read is outstanding. `mode_o` shows the new value in the next cycle.
- R3: A mode write issued while a flash read is outstanding is ignored.
- R4: With mode bit 0 clear, a fetch accepted at a clock edge produces a single-cycle `fetch_rvalid_o` in the cycle right after that edge, carrying the word stored at the fetch address.
- R5: With mode bit 0 set, `fetch_rvalid_o` comes 1 + `SLOW_WS` cycles after the accepting edge, for exactly one cycle.
- R6: Only one read is outstanding at a time. `fetch_ready_o` stays low from the accepting edge until the cycle after the valid pulse.
- R7: With mode bit 1 clear, a fetch flagged as a branch-target prefetch is read from flash and returned like any other fetch.
- R8: With mode bit 1 set, a flagged fetch is accepted, issues no flash read, returns no data, and leaves `fetch_ready_o` high.
- R9: A taken resolution while a target is parked issues the parked address to flash in the first cycle after the resolution in which no read is outstanding. The word returns with the latency of the current mode.
- R10: A not-taken resolution discards the parked target, with no flash read and no returned data.
- R11: The read counter increases by exactly one for each cycle in which `flash_rd_o` is high, and by nothing otherwise.
- R12: A resolution strobe while no target is parked has no effect: no flash read and no returned data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_we_i | input | 1 | Mode register write strobe |
| mode_wdata_i | input | 2 | New mode value |
| mode_o | output | 2 | Current mode |
| fetch_req_i | input | 1 | Fetch request |
| fetch_addr_i | input | AW | Fetch address |
| fetch_spec_i | input | 1 | Fetch is a speculative conditional-branch-target prefetch |
| fetch_ready_o | output | 1 | Fetch can be accepted this cycle |
| fetch_rvalid_o | output | 1 | Fetch data valid pulse |
| fetch_rdata_o | output | DW | Fetch data |
| br_resolve_i | input | 1 | Branch outcome strobe |
| br_taken_i | input | 1 | Outcome: branch taken |
| flash_rd_o | output | 1 | Flash read strobe |
| flash_addr_o | output | AW | Flash read address |
| flash_rdata_i | input | DW | Flash word, valid from the cycle after the strobe |
| rd_count_o | output | CNT_W | Number of flash reads issued |

## Verification
The directed cases are the latency edges of each mode, a mode write landing in the middle of a read, a resolution with nothing parked, and a taken resolution that arrives while a sequential read is still in flight. A design that got these wrong would pulse valid one cycle early or late, change its wait count under a running read, issue a read for a stale address, or drop the replay because it came while busy. Random runs mix mode changes, plain fetches and branch episodes with random outcomes. The expected read count is tracked in the bench, so a suppressing mode that still sends prefetches to flash, or a not-taken drop that still reads, shows up as a count mismatch.

// File: rtl/ffc_pkg.sv
package ffc_pkg;

  typedef enum logic [1:0] {
    MODE_WS0     = 2'b00,
    MODE_WS1     = 2'b01,
    MODE_WS0_SUP = 2'b10,
    MODE_WS1_SUP = 2'b11
  } ffc_mode_e;

  typedef enum logic [1:0] {
    DF_EMPTY  = 2'b00,
    DF_HELD   = 2'b01,
    DF_REPLAY = 2'b10
  } ffc_defer_e;

endpackage

// File: rtl/ffc_mode_reg.sv
module ffc_mode_reg
  import ffc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      we_i,
  input  ffc_mode_e wdata_i,
  input  logic      busy_i,
  output ffc_mode_e mode_o
);

  ffc_mode_e mode_q;
  ffc_mode_e mode_d;
  logic      mode_en;

  // a write lands only while no read is in flight
  assign mode_en = we_i && !busy_i;

  always_comb begin
    mode_d = mode_q;
    if (mode_en) mode_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= MODE_WS0;
    else if (mode_en) mode_q <= mode_d;
  end

  assign mode_o = mode_q;

  AST_MODE_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> $stable(mode_q)); // R3

endmodule

// File: rtl/ffc_wait_timer.sv
module ffc_wait_timer #(
  parameter int WS_W = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [WS_W-1:0] waits_i,
  output logic            busy_o,
  output logic            done_o
);

  logic            busy_q, busy_d;
  logic [WS_W-1:0] cnt_q, cnt_d;
  logic            tmr_en;

  assign done_o = busy_q && (cnt_q == '0);
  assign tmr_en = start_i || busy_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (start_i) begin
      busy_d = 1'b1;
      cnt_d  = waits_i;
    end else if (done_o) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d = cnt_q - WS_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (tmr_en) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy_o = busy_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R5

  AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_q); // R6

endmodule

// File: rtl/ffc_defer.sv
module ffc_defer
  import ffc_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture_i,
  input  logic [AW-1:0] cap_addr_i,
  input  logic          resolve_i,
  input  logic          taken_i,
  input  logic          issue_i,
  output logic          held_o,
  output logic          replay_o,
  output logic [AW-1:0] addr_o
);

  ffc_defer_e    st_q, st_d;
  logic [AW-1:0] addr_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      DF_EMPTY:  if (capture_i) st_d = DF_HELD;
      DF_HELD: begin
        if (resolve_i)      st_d = taken_i ? DF_REPLAY : DF_EMPTY;
        else if (capture_i) st_d = DF_HELD;
      end
      DF_REPLAY: if (issue_i) st_d = DF_EMPTY;
      default:   st_d = DF_EMPTY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= DF_EMPTY;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         addr_q <= '0;
    else if (capture_i) addr_q <= cap_addr_i;
  end

  assign held_o   = (st_q == DF_HELD);
  assign replay_o = (st_q == DF_REPLAY);
  assign addr_o   = addr_q;

  AST_REPLAY_PERSIST: assert property (@(posedge clk) disable iff (!rst_n)
    (replay_o && !issue_i) |=> replay_o); // R9

endmodule

// File: rtl/ffc_rd_counter.sv
module ffc_rd_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  output logic [CNT_W-1:0] count_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign count_o = cnt_q;

  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !inc_i |=> $stable(cnt_q)); // R11

endmodule

// File: rtl/flash_fetch_ws_ctrl.sv
module flash_fetch_ws_ctrl
  import ffc_pkg::*;
#(
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int SLOW_WS = 1,
  parameter int CNT_W   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_we_i,
  input  logic [1:0]       mode_wdata_i,
  output logic [1:0]       mode_o,
  input  logic             fetch_req_i,
  input  logic [AW-1:0]    fetch_addr_i,
  input  logic             fetch_spec_i,
  output logic             fetch_ready_o,
  output logic             fetch_rvalid_o,
  output logic [DW-1:0]    fetch_rdata_o,
  input  logic             br_resolve_i,
  input  logic             br_taken_i,
  output logic             flash_rd_o,
  output logic [AW-1:0]    flash_addr_o,
  input  logic [DW-1:0]    flash_rdata_i,
  output logic [CNT_W-1:0] rd_count_o
);

  localparam int              WS_W     = $clog2(SLOW_WS + 1);
  localparam logic [WS_W-1:0] SLOW_CNT = WS_W'(SLOW_WS);

  ffc_mode_e       mode_q;
  logic            busy;
  logic            done;
  logic            held;
  logic            replay;
  logic [AW-1:0]   defer_addr;
  logic            accept;
  logic            suppress;
  logic            capture;
  logic            replay_issue;
  logic [WS_W-1:0] waits;

  ffc_mode_reg u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (mode_we_i),
    .wdata_i (ffc_mode_e'(mode_wdata_i)),
    .busy_i  (busy),
    .mode_o  (mode_q)
  );

  // mode bit 1: suppression, mode bit 0: slow wait count
  assign waits         = mode_q[0] ? SLOW_CNT : '0;
  assign fetch_ready_o = !busy && !replay;
  assign accept        = fetch_req_i && fetch_ready_o;
  assign suppress      = mode_q[1] && fetch_spec_i;
  assign capture       = accept && suppress;
  assign replay_issue  = replay && !busy;
  assign flash_rd_o    = replay_issue || (accept && !suppress);
  assign flash_addr_o  = replay_issue ? defer_addr : fetch_addr_i;

  ffc_wait_timer #(.WS_W(WS_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (flash_rd_o),
    .waits_i (waits),
    .busy_o  (busy),
    .done_o  (done)
  );

  ffc_defer #(.AW(AW)) u_defer (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture_i  (capture),
    .cap_addr_i (fetch_addr_i),
    .resolve_i  (br_resolve_i),
    .taken_i    (br_taken_i),
    .issue_i    (replay_issue),
    .held_o     (held),
    .replay_o   (replay),
    .addr_o     (defer_addr)
  );

  ffc_rd_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc_i   (flash_rd_o),
    .count_o (rd_count_o)
  );

  assign mode_o         = mode_q;
  assign fetch_rvalid_o = done;
  assign fetch_rdata_o  = flash_rdata_i;

  AST_FAST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (flash_rd_o && !mode_q[0]) |=> fetch_rvalid_o); // R4

  AST_SLOW_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    (flash_rd_o && mode_q[0]) |=> !fetch_rvalid_o); // R5

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    flash_rd_o |=> (rd_count_o == $past(rd_count_o) + CNT_W'(1))); // R11

  AST_SUP_STAYS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && mode_q[1] && fetch_spec_i) |=> fetch_ready_o); // R8

  AST_NT_NO_REPLAY: assert property (@(posedge clk) disable iff (!rst_n)
    (br_resolve_i && !br_taken_i) |=> !replay); // R10

  AST_EMPTY_RESOLVE: assert property (@(posedge clk) disable iff (!rst_n)
    (br_resolve_i && !held && !replay) |=> !replay); // R12

endmodule

// File: tb/test_flash_fetch_ws_ctrl.sv
module test_flash_fetch_ws_ctrl;

  localparam int AW = 32;
  localparam int DW = 32;
  localparam int CW = 32;
  localparam int WS = 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_we = 1'b0;
  logic [1:0]    mode_wdata = '0;
  logic [1:0]    mode_o;
  logic          fetch_req = 1'b0;
  logic [AW-1:0] fetch_addr = '0;
  logic          fetch_spec = 1'b0;
  logic          fetch_ready;
  logic          fetch_rvalid;
  logic [DW-1:0] fetch_rdata;
  logic          br_resolve = 1'b0;
  logic          br_taken = 1'b0;
  logic          flash_rd;
  logic [AW-1:0] flash_addr;
  logic [DW-1:0] flash_q = '0;
  logic [CW-1:0] rd_count;

  int            nchk = 0;
  int            nfail = 0;
  int            seen_rd = 0;
  int            exp_rd = 0;
  logic [1:0]    m_mode = 2'b00;
  bit            m_held = 1'b0;
  logic [AW-1:0] m_daddr = '0;
  bit            finished = 1'b0;

  always #5 clk = ~clk;

  flash_fetch_ws_ctrl #(.AW(AW), .DW(DW), .SLOW_WS(WS), .CNT_W(CW)) i_flash_fetch_ws_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .mode_we_i      (mode_we),
    .mode_wdata_i   (mode_wdata),
    .mode_o         (mode_o),
    .fetch_req_i    (fetch_req),
    .fetch_addr_i   (fetch_addr),
    .fetch_spec_i   (fetch_spec),
    .fetch_ready_o  (fetch_ready),
    .fetch_rvalid_o (fetch_rvalid),
    .fetch_rdata_o  (fetch_rdata),
    .br_resolve_i   (br_resolve),
    .br_taken_i     (br_taken),
    .flash_rd_o     (flash_rd),
    .flash_addr_o   (flash_addr),
    .flash_rdata_i  (flash_q),
    .rd_count_o     (rd_count)
  );

  function automatic logic [DW-1:0] word_at(input logic [AW-1:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  // flash array model: word ready the cycle after the strobe, held until the next read
  always @(posedge clk) begin
    if (rst_n && flash_rd) begin
      flash_q <= word_at(flash_addr);
      seen_rd = seen_rd + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic chk_count();
    chk(rd_count == CW'(exp_rd), "R11 counter", 64'(rd_count), 64'(exp_rd));
    chk(seen_rd == exp_rd, "R11 strobes", 64'(seen_rd), 64'(exp_rd));
  endtask

  // watch len negedges; valid expected only on the hit-th one
  task automatic wait_window(input int hit, input logic [DW-1:0] d, input int len, input string req);
    for (int i = 1; i <= len; i++) begin
      @(negedge clk);
      chk(fetch_rvalid == (i == hit), req, 64'(fetch_rvalid), 64'(i == hit));
      if (i == hit) chk(fetch_rdata == d, req, 64'(fetch_rdata), 64'(d));
    end
  endtask

  task automatic mode_write(input logic [1:0] v);
    mode_we    = 1'b1;
    mode_wdata = v;
    @(negedge clk);
    mode_we = 1'b0;
    m_mode  = v;
    chk(mode_o == v, "R2 mode write", 64'(mode_o), 64'(v));
  endtask

  task automatic fetch(input logic [AW-1:0] a, input bit spec);
    bit    sup;
    int    n;
    string tag;
    sup = m_mode[1] && spec;
    n   = m_mode[0] ? WS : 0;
    tag = sup ? "R8" : (spec ? "R7" : (m_mode[0] ? "R5" : "R4"));
    chk(fetch_ready == 1'b1, "R6 ready idle", 64'(fetch_ready), 64'd1);
    fetch_req  = 1'b1;
    fetch_addr = a;
    fetch_spec = spec;
    @(negedge clk);
    fetch_req  = 1'b0;
    fetch_spec = 1'b0;
    if (sup) begin
      m_held  = 1'b1;
      m_daddr = a;
      chk(fetch_ready == 1'b1, "R8 ready kept", 64'(fetch_ready), 64'd1);
      chk(fetch_rvalid == 1'b0, "R8 no data", 64'(fetch_rvalid), 64'd0);
      wait_window(0, '0, 2, "R8 no data");
    end else begin
      exp_rd++;
      chk(fetch_ready == 1'b0, "R6 ready low while busy", 64'(fetch_ready), 64'd0);
      for (int k = 1; k <= n + 2; k++) begin
        if (k > 1) @(negedge clk);
        chk(fetch_rvalid == (k == n + 1), tag, 64'(fetch_rvalid), 64'(k == n + 1));
        if (k == n + 1) chk(fetch_rdata == word_at(a), tag, 64'(fetch_rdata), 64'(word_at(a)));
      end
      chk(fetch_ready == 1'b1, "R6 ready back", 64'(fetch_ready), 64'd1);
    end
    chk_count();
  endtask

  task automatic resolve(input bit taken);
    int n;
    n = m_mode[0] ? WS : 0;
    br_resolve = 1'b1;
    br_taken   = taken;
    @(negedge clk);
    br_resolve = 1'b0;
    br_taken   = 1'b0;
    if (m_held && taken) begin
      exp_rd++;
      m_held = 1'b0;
      chk(fetch_rvalid == 1'b0, "R9 replay", 64'(fetch_rvalid), 64'd0);
      wait_window(n + 1, word_at(m_daddr), n + 2, "R9 replay");
    end else begin
      if (m_held) begin
        m_held = 1'b0;
        wait_window(0, '0, 2, "R10 drop");
      end else begin
        wait_window(0, '0, 2, "R12 empty resolve");
      end
    end
    chk(fetch_ready == 1'b1, "R6 ready after resolve", 64'(fetch_ready), 64'd1);
    chk_count();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] ra;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(mode_o == 2'b00, "R1 mode", 64'(mode_o), 64'd0);
    chk(rd_count == '0, "R1 count", 64'(rd_count), 64'd0);
    chk(fetch_ready == 1'b1, "R1 ready", 64'(fetch_ready), 64'd1);
    chk(flash_rd == 1'b0, "R1 flash_rd", 64'(flash_rd), 64'd0);
    chk(fetch_rvalid == 1'b0, "R1 rvalid", 64'(fetch_rvalid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    fetch(32'h0000_0100, 1'b0);              // R4
    mode_write(2'b01);                       // R2
    fetch(32'h0000_0104, 1'b0);              // R5
    fetch(32'h0000_0108, 1'b1);              // R7 in a slow mode
    mode_write(2'b11);
    fetch(32'h0000_0200, 1'b1);              // R8
    resolve(1'b1);                           // R9
    fetch(32'h0000_0300, 1'b1);
    resolve(1'b0);                           // R10
    resolve(1'b1);                           // R12
    mode_write(2'b00);
    fetch(32'h0000_0400, 1'b1);              // R7
    mode_write(2'b10);
    fetch(32'h0000_0500, 1'b1);
    resolve(1'b1);                           // R9 with no wait states

    // R3: write during an outstanding read is ignored
    mode_write(2'b01);
    fetch_req  = 1'b1;
    fetch_addr = 32'h0000_0600;
    @(negedge clk);
    fetch_req  = 1'b0;
    exp_rd++;
    chk(fetch_rvalid == 1'b0, "R5 not early", 64'(fetch_rvalid), 64'd0);
    mode_we    = 1'b1;
    mode_wdata = 2'b10;
    @(negedge clk);
    mode_we = 1'b0;
    chk(fetch_rvalid == 1'b1, "R5 slow hit", 64'(fetch_rvalid), 64'd1);
    chk(fetch_rdata == word_at(32'h0000_0600), "R5 slow data", 64'(fetch_rdata), 64'(word_at(32'h0000_0600)));
    chk(mode_o == 2'b01, "R3 write ignored while busy", 64'(mode_o), 64'd1);
    @(negedge clk);
    chk_count();

    // R9: taken resolution arrives while a sequential read is in flight
    mode_write(2'b11);
    fetch(32'h0000_0700, 1'b1);
    fetch_req  = 1'b1;
    fetch_addr = 32'h0000_0704;
    @(negedge clk);
    fetch_req  = 1'b0;
    exp_rd += 2;
    chk(fetch_rvalid == 1'b0, "R9 seq not early", 64'(fetch_rvalid), 64'd0);
    br_resolve = 1'b1;
    br_taken   = 1'b1;
    wait_window(1, word_at(32'h0000_0704), 1, "R9 seq during resolve");
    br_resolve = 1'b0;
    br_taken   = 1'b0;
    wait_window(3, word_at(32'h0000_0700), 4, "R9 replay after busy");
    m_held = 1'b0;
    chk(fetch_ready == 1'b1, "R6 ready after replay", 64'(fetch_ready), 64'd1);
    chk_count();

    // constrained random mix
    for (int it = 0; it < 400; it++) begin
      int op;
      op = $urandom_range(0, 6);
      ra = $urandom() & 32'hFFFF_FFFC;
      case (op)
        0, 1: fetch(ra, 1'b0);
        2:    mode_write(2'($urandom_range(0, 3)));
        3, 4, 5: begin
          fetch(ra, 1'b1);
          if ($urandom_range(0, 1) == 1) fetch(ra + 32'd4, 1'b0);
          resolve(1'($urandom_range(0, 1)));
        end
        default: resolve(1'($urandom_range(0, 1)));   // R12 nothing parked
      endcase
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule